// File: doc/BRIEF.md
# Host Serial Read/Load Port

This block is the host-facing side of a dual-slope converter controller. One serial clock serves two operations. While the read strobe is low, the port shifts out the last conversion result as an 18-bit frame. While the load strobe is low, it shifts in an 8-bit count byte for the timebase. All host pins are treated as asynchronous. They pass through a synchronizer of configurable depth, and the logic acts on the resulting clean edges.

When the read strobe falls, the port copies the result bus into a frame register. It holds that copy for the whole read. The pad driver uses `sdo_oe` as its enable, so the output floats whenever no read is in progress. When the load strobe rises, the port sends the sequencer one single-cycle update pulse together with the byte. The byte comes from one of two places. If the host clocked any bits in, the byte is what was shifted in. If the strobe was only pulsed, the byte is one of two default counts, picked by the level of the data input.

Top module: `hsp_serial_port`

## Requirements
- R1: A falling read strobe captures the result bus into the frame register and enables the output (`sdo_oe`=1). The overrange bit is presented on `sdo` at once, before any clock edge.
- R2: The frame order is overrange, then polarity, then data bits 15 down to 0. Each falling serial-clock edge during a read advances one bit. Rising edges leave `sdo` unchanged.
- R3: While the read strobe is high, `sdo_oe` is 0 and `sdo` is held at 0.
- R4: Raising the read strobe ends a read after any number of bits. The next falling read strobe takes a fresh copy of the result bus and starts again with the overrange bit.
- R5: Changes on the result bus during a read do not alter the bits being shifted out.
- R6: While the load strobe is low, `sdi` is sampled on each rising serial-clock edge and shifted in MSB first. The shift register is cleared when the load strobe falls, so fewer than 8 bits end up right-aligned (for example, bits 1,0,1 give 0x05).
- R7: Each rising load strobe gives exactly one single-cycle `cnt_update` pulse, with the byte on `cnt_byte`.
- R8: A load strobe with no rising clock edges selects a default byte from the `sdi` level at the rising strobe. A high level gives 0x00 (a count of 65536). A low level gives 0x80 (a count of 32768).
- R9: After reset, `sdo_oe`, `sdo` and `cnt_update` are 0, and `cnt_byte` is 0x00.
- R10: Serial-clock activity and read cycles with the load strobe high produce no `cnt_update` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| read_n | input | 1 | Read strobe from host, active low |
| load_n | input | 1 | Load strobe from host, active low |
| sclk | input | 1 | Shared serial clock from host |
| sdi | input | 1 | Serial data from host |
| result_ovr | input | 1 | Overrange bit of latest conversion |
| result_pol | input | 1 | Polarity bit of latest conversion (1 = positive) |
| result_data | input | 16 | Magnitude of latest conversion |
| sdo | output | 1 | Serial data to host |
| sdo_oe | output | 1 | Output enable for the `sdo` pad driver |
| cnt_update | output | 1 | Single-cycle strobe to the sequencer |
| cnt_byte | output | 8 | Count byte delivered with `cnt_update` |

## Verification
The bench changes the result bus in the middle of every read. A port that failed to freeze its copy would show the new value in the later bits. It also checks `sdo` after each rising clock edge, which catches a shifter that moves on both edges. Loads are tested three ways: full bytes, a strobe pulsed with `sdi` high or low, and a partial three-bit load. A design that ignored the edge count, forgot to clear the register, or swapped the default bytes would give the wrong `cnt_byte`. A read cut short and then restarted must begin again from the overrange bit of a newly captured result.

// File: rtl/hsp_pkg.sv
package hsp_pkg;

    localparam int DATA_W  = 16;
    localparam int FRAME_W = DATA_W + 2;
    localparam int BYTE_W  = 8;

    typedef struct packed {
        logic              ovr;
        logic              pol;
        logic [DATA_W-1:0] mag;
    } conv_word_t;

    typedef struct packed {
        logic rd_fall;
        logic rd_low;
        logic ld_fall;
        logic ld_rise;
        logic ld_low;
        logic ck_rise;
        logic ck_fall;
        logic din;
    } pin_evt_t;

    function automatic logic [BYTE_W-1:0] default_count_byte(input logic lvl);
        return lvl ? '0 : {1'b1, {(BYTE_W-1){1'b0}}};
    endfunction

    function automatic logic [FRAME_W-1:0] pack_frame(input conv_word_t w);
        return {w.ovr, w.pol, w.mag};
    endfunction

endpackage

// File: rtl/hsp_pin_sync.sv
module hsp_pin_sync #(
    parameter int           STAGES  = 2,
    parameter int           N       = 4,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] lvl_o,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);
    logic [N-1:0] prev_q;

    for (genvar g = 0; g < N; g++) begin : g_pin
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk) begin
            if (rst) chain_q <= {STAGES{RST_VAL[g]}};
            else     chain_q <= {chain_q[STAGES-2:0], pin_i[g]};
        end
        assign lvl_o[g] = chain_q[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= RST_VAL;
        else     prev_q <= lvl_o;
    end

    assign rise_o = lvl_o & ~prev_q;
    assign fall_o = ~lvl_o & prev_q;
endmodule

// File: rtl/hsp_read_shifter.sv
module hsp_read_shifter
    import hsp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  conv_word_t result_i,
    input  logic       rd_fall,
    input  logic       rd_low,
    input  logic       ck_fall,
    output logic       sdo_o,
    output logic       sdo_oe_o
);
    logic [FRAME_W-1:0] frame_q;
    logic               oe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= '0;
            oe_q    <= 1'b0;
        end else begin
            oe_q <= rd_low;
            if (rd_fall)
                frame_q <= pack_frame(result_i);
            else if (rd_low && ck_fall)
                frame_q <= {frame_q[FRAME_W-2:0], 1'b0};
        end
    end

    assign sdo_oe_o = oe_q;
    assign sdo_o    = oe_q & frame_q[FRAME_W-1];
endmodule

// File: rtl/hsp_load_shifter.sv
module hsp_load_shifter
    import hsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_fall,
    input  logic              ld_rise,
    input  logic              ld_low,
    input  logic              ck_rise,
    input  logic              din,
    output logic              upd_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              seen_o
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(BYTE_W);

    logic [BYTE_W-1:0] sh_q;
    logic [CNT_W-1:0]  edges_q;

    assign seen_o = (edges_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q    <= '0;
            edges_q <= '0;
            upd_o   <= 1'b0;
            byte_o  <= '0;
        end else begin
            upd_o <= 1'b0;
            if (ld_fall) begin
                sh_q    <= '0;
                edges_q <= '0;
            end else if (ld_low && ck_rise) begin
                sh_q <= {sh_q[BYTE_W-2:0], din};
                if (edges_q != CNT_MAX) edges_q <= edges_q + 1'b1;
            end
            if (ld_rise) begin
                upd_o  <= 1'b1;
                byte_o <= seen_o ? sh_q : default_count_byte(din);
            end
        end
    end
endmodule

// File: rtl/hsp_serial_port.sv
module hsp_serial_port
    import hsp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              read_n,
    input  logic              load_n,
    input  logic              sclk,
    input  logic              sdi,
    input  logic              result_ovr,
    input  logic              result_pol,
    input  logic [DATA_W-1:0] result_data,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              cnt_update,
    output logic [BYTE_W-1:0] cnt_byte
);
    localparam int NPIN = 4;
    localparam int P_RD = 3;
    localparam int P_LD = 2;
    localparam int P_CK = 1;
    localparam int P_DI = 0;

    logic [NPIN-1:0] lvl, rise, fall;
    pin_evt_t        evt;
    conv_word_t      result;
    logic            sclk_fall_s;
    logic            ld_seen_s;

    hsp_pin_sync #(
        .STAGES (SYNC_STAGES),
        .N      (NPIN),
        .RST_VAL(4'b1100)
    ) sync_i (
        .clk   (clk),
        .rst   (rst),
        .pin_i ({read_n, load_n, sclk, sdi}),
        .lvl_o (lvl),
        .rise_o(rise),
        .fall_o(fall)
    );

    always_comb begin
        evt.rd_fall = fall[P_RD];
        evt.rd_low  = ~lvl[P_RD];
        evt.ld_fall = fall[P_LD];
        evt.ld_rise = rise[P_LD];
        evt.ld_low  = ~lvl[P_LD];
        evt.ck_rise = rise[P_CK];
        evt.ck_fall = fall[P_CK];
        evt.din     = lvl[P_DI];
    end

    assign result      = '{ovr: result_ovr, pol: result_pol, mag: result_data};
    assign sclk_fall_s = evt.ck_fall;

    hsp_read_shifter rd_i (
        .clk     (clk),
        .rst     (rst),
        .result_i(result),
        .rd_fall (evt.rd_fall),
        .rd_low  (evt.rd_low),
        .ck_fall (evt.ck_fall),
        .sdo_o   (sdo),
        .sdo_oe_o(sdo_oe)
    );

    hsp_load_shifter ld_i (
        .clk    (clk),
        .rst    (rst),
        .ld_fall(evt.ld_fall),
        .ld_rise(evt.ld_rise),
        .ld_low (evt.ld_low),
        .ck_rise(evt.ck_rise),
        .din    (evt.din),
        .upd_o  (cnt_update),
        .byte_o (cnt_byte),
        .seen_o (ld_seen_s)
    );
endmodule

// File: rtl/hsp_serial_port_chk.sv
module hsp_serial_port_chk
    import hsp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              sdo,
    input logic              sdo_oe,
    input logic              result_ovr,
    input logic              cnt_update,
    input logic [BYTE_W-1:0] cnt_byte,
    input logic              sclk_fall_s,
    input logic              ld_seen_s
);
    // R7
    upd_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_update |=> !cnt_update);

    // R1
    ovr_first_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sdo_oe) |-> sdo == $past(result_ovr));

    // R2
    shift_on_fall_only_chk: assert property (@(posedge clk) disable iff (rst)
        (sdo_oe && $past(sdo_oe) && !$past(sclk_fall_s)) |-> $stable(sdo));

    // R8
    default_byte_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_update && !$past(ld_seen_s)) |-> (cnt_byte[BYTE_W-2:0] == '0));
endmodule

bind hsp_serial_port hsp_serial_port_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .sdo        (sdo),
    .sdo_oe     (sdo_oe),
    .result_ovr (result_ovr),
    .cnt_update (cnt_update),
    .cnt_byte   (cnt_byte),
    .sclk_fall_s(sclk_fall_s),
    .ld_seen_s  (ld_seen_s)
);

// File: tb/hsp_serial_port_tb_top.sv
module hsp_serial_port_tb_top;
    import hsp_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst = 1'b1;
    logic read_n = 1'b1, load_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic result_ovr = 1'b0, result_pol = 1'b0;
    logic [15:0] result_data = '0;
    logic sdo, sdo_oe, cnt_update;
    logic [7:0] cnt_byte;

    hsp_serial_port dut_i (
        .clk(clk), .rst(rst), .read_n(read_n), .load_n(load_n), .sclk(sclk),
        .sdi(sdi), .result_ovr(result_ovr), .result_pol(result_pol),
        .result_data(result_data), .sdo(sdo), .sdo_oe(sdo_oe),
        .cnt_update(cnt_update), .cnt_byte(cnt_byte)
    );

    // frame {ovr,pol,data[15:0]} and load byte
    localparam logic [25:0] VEC [0:5] = '{
        {1'b0, 1'b1, 16'hA5C3, 8'h3C},
        {1'b1, 1'b0, 16'hFFFF, 8'h00},
        {1'b0, 1'b0, 16'h0000, 8'hFF},
        {1'b1, 1'b1, 16'h8001, 8'h80},
        {1'b0, 1'b1, 16'h7FFE, 8'h5A},
        {1'b1, 1'b0, 16'h1234, 8'hC7}
    };

    int total = 0, bad = 0, pulses = 0;
    logic [7:0] last_byte = '0;

    always @(negedge clk)
        if (!rst && cnt_update) begin
            pulses++;
            last_byte = cnt_byte;
        end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold();
        repeat (6) @(negedge clk);
    endtask

    task automatic set_result(input logic [17:0] f);
        {result_ovr, result_pol, result_data} = f;
    endtask

    task automatic read_frame(input logic [17:0] f);
        int p0;
        p0 = pulses;
        set_result(f);
        hold();
        read_n = 1'b0;
        hold();
        chk("R1 oe", 32'(sdo_oe), 32'd1);
        chk("R1 ovr first", 32'(sdo), 32'(f[17]));
        set_result(~f);  // R5: bus moves during read
        for (int i = 1; i < 18; i++) begin
            sclk = 1'b1;
            hold();
            chk("R2 rise holds", 32'(sdo), 32'(f[18-i]));
            sclk = 1'b0;
            hold();
            chk("R2 R5 bit", 32'(sdo), 32'(f[17-i]));
        end
        read_n = 1'b1;
        hold();
        chk("R3 oe off", 32'(sdo_oe), 32'd0);
        chk("R3 sdo low", 32'(sdo), 32'd0);
        chk("R10 no update in read", 32'(pulses - p0), 32'd0);
    endtask

    task automatic load_bits(input logic [7:0] b, input int n);
        int p0;
        p0 = pulses;
        load_n = 1'b0;
        hold();
        for (int i = n - 1; i >= 0; i--) begin
            sdi = b[i];
            hold();
            sclk = 1'b1;
            hold();
            sclk = 1'b0;
            hold();
        end
        load_n = 1'b1;
        hold();
        chk("R7 one pulse", 32'(pulses - p0), 32'd1);
    endtask

    task automatic load_default(input logic lvl, input logic [7:0] exp);
        int p0;
        p0 = pulses;
        sdi = lvl;
        hold();
        load_n = 1'b0;
        hold();
        load_n = 1'b1;
        hold();
        chk("R7 default pulse", 32'(pulses - p0), 32'd1);
        chk("R8 default byte", 32'(last_byte), 32'(exp));
    endtask

    initial begin
        #(8 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        hold();
        // R9
        chk("R9 oe", 32'(sdo_oe), 32'd0);
        chk("R9 sdo", 32'(sdo), 32'd0);
        chk("R9 update", 32'(cnt_update), 32'd0);
        chk("R9 byte", 32'(cnt_byte), 32'd0);

        for (int v = 0; v < 6; v++) begin
            read_frame(VEC[v][25:8]);
            load_bits(VEC[v][7:0], 8);
            chk("R6 byte", 32'(last_byte), 32'(VEC[v][7:0]));
        end

        // R8 defaults
        load_default(1'b1, 8'h00);
        load_default(1'b0, 8'h80);

        // R6 partial load
        load_bits(8'h05, 3);
        chk("R6 partial", 32'(last_byte), 32'h05);

        // R4 early termination and restart
        set_result({1'b1, 1'b0, 16'h0F0F});
        hold();
        read_n = 1'b0;
        hold();
        for (int i = 0; i < 3; i++) begin
            sclk = 1'b1; hold();
            sclk = 1'b0; hold();
        end
        read_n = 1'b1;
        hold();
        chk("R4 oe off", 32'(sdo_oe), 32'd0);
        set_result({1'b0, 1'b1, 16'hC000});
        hold();
        read_n = 1'b0;
        hold();
        chk("R4 restart ovr", 32'(sdo), 32'd0);
        sclk = 1'b1; hold();
        sclk = 1'b0; hold();
        chk("R4 restart pol", 32'(sdo), 32'd1);
        sclk = 1'b1; hold();
        sclk = 1'b0; hold();
        chk("R4 restart d15", 32'(sdo), 32'd1);
        read_n = 1'b1;
        hold();

        // R10 clocks with both strobes high
        begin
            int p0;
            p0 = pulses;
            for (int i = 0; i < 5; i++) begin
                sclk = 1'b1; hold();
                sclk = 1'b0; hold();
            end
            chk("R10 idle clocks", 32'(pulses - p0), 32'd0);
            chk("R10 oe idle", 32'(sdo_oe), 32'd0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule